// File: doc/BRIEF.md
# Drive Transfer Byte Counter and Control Registers

This block holds the setup and progress state of a byte-counted transfer between a local buffer and an external storage drive. Firmware reaches it through a byte-wide register port. It loads a 32-bit byte total, which the port exposes as four byte registers, and then watches the total count down as the data path strobes each byte across. A single control register carries several settings: the drive pin output enable, an abort command, a read-only error flag, the ping-pong buffer toggle and auto-transfer enables, the UDMA enable, and a completion flag for programmed (PIO) accesses to drive registers. The completion flag is also routed to an interrupt output.

Firmware arms a transfer in two steps. It writes the upper count bytes first. These writes only stage the values. It then writes the lowest count byte, which loads the whole counter and starts the transfer. Reading a count register always returns the bytes still outstanding. An abort command or an early end signalled by the data path leaves a sticky error, and the next arming write clears it. While the error stands, the block asks the data path to hold its buffer selection so that firmware can inspect it.

Top module: `ata_xfer_regs`

## Requirements
- R1: After reset, all four count registers read 0x00 and the control register reads 0x02. The output enable, abort, error, active, hold, toggle, auto-transfer, UDMA and interrupt outputs are all 0.
- R2: A write to count byte 1, 2 or 3 only stages the value. It changes neither the count read back nor the active state. A write to count byte 0 loads {byte3,byte2,byte1,written byte} into the counter on the next clock. The transfer becomes active only if the loaded value is nonzero.
- R3: Count byte k (k=0..3) is read at address 0xE1+k and returns bits 8k+7:8k of the live remaining count. The control register is at 0xDD. Any other address reads 0x00.
- R4: While the transfer is active, each cycle with the byte strobe high decrements the count by one. On reaching zero the transfer ends without an error. When the transfer is not active, strobes change nothing, so the count never falls below zero.
- R5: Writing the control register with bit 5 set sets the abort flag (read bit 5) and the error flag (read bit 4). It also ends the transfer and freezes the count. Writing bit 5 as 0 leaves the abort flag unchanged.
- R6: An early-end pulse while the transfer is active sets the error flag and ends the transfer. An early-end pulse while the transfer is not active has no effect.
- R7: An arming write clears the abort and error flags. This holds even when an early-end pulse arrives in the same cycle.
- R8: The PIO-complete flag (control bit 6) sets on a done pulse. It clears on a start pulse or on a control write with bit 6 set. A done pulse wins over either clear in the same cycle. The interrupt output equals the flag.
- R9: Control bits 7 (pin output enable), 3 (buffer toggle), 2 (auto-transfer) and 0 (UDMA enable) are read/write and drive their outputs. Bit 1 always reads 1.
- R10: The effective buffer toggle output is high whenever bit 3 or bit 2 is set.
- R11: The buffer-hold output is high exactly while the error flag is set.
- R12: Within one cycle the priority is abort write, then early end, then byte strobe. A strobe that coincides with either of the other two does not decrement the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| xfer_byte_i | input | 1 | One byte moved by the data path |
| xfer_end_i | input | 1 | Data path ended the transfer |
| pio_start_i | input | 1 | PIO access to drive registers begins |
| pio_done_i | input | 1 | PIO access to drive registers finished |
| pin_oe_o | output | 1 | Drive pin output enable |
| abort_o | output | 1 | Abort flag |
| err_o | output | 1 | Sticky error flag |
| xfer_active_o | output | 1 | Transfer in progress |
| buf_hold_o | output | 1 | Freeze ping-pong buffer selection |
| buf_tog_en_o | output | 1 | Effective buffer auto-toggle enable |
| auto_xfer_o | output | 1 | Auto-transfer enable |
| udma_en_o | output | 1 | UDMA enable for drive 0 |
| pio_irq_o | output | 1 | Interrupt mirror of PIO-complete |

## Verification
The hardest situations to reach are same-cycle collisions. Examples are an arming write that meets an early-end pulse, an abort write that meets a byte strobe, and a done pulse that meets a write-one-to-clear. The stimulus drives every input from one task per cycle, so each such pair can be placed on the same clock edge on purpose. A behavioural model then settles the outcome independently. The count is read back through every byte address after strobes that arrive while inactive, so the test can show that the count does not move.

// File: rtl/ata_regs_pkg.sv
package ata_regs_pkg;
  localparam int CTL_OE    = 7;
  localparam int CTL_PIO   = 6;
  localparam int CTL_ABORT = 5;
  localparam int CTL_ERR   = 4;
  localparam int CTL_TOG   = 3;
  localparam int CTL_AUTO  = 2;
  localparam int CTL_RSVD  = 1;
  localparam int CTL_UDMA  = 0;

  typedef struct packed {
    logic oe;
    logic pio;
    logic abort;
    logic err;
    logic tog;
    logic auto_x;
    logic rsvd;
    logic udma;
  } ctl_t;
endpackage

// File: rtl/ata_byte_cnt.sv
module ata_byte_cnt #(
  parameter int CNT_W = 32,
  localparam int NB   = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    byte_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             abort_i,
  input  logic             end_i,
  input  logic             strobe_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             early_o
);
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             arm;

  assign arm = byte_we_i[0];

  // upper bytes are staged only; byte 0 slot is unused
  assign stage_q[7:0] = 8'h00;
  for (genvar b = 1; b < NB; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           stage_q[b*8 +: 8] <= 8'h00;
      else if (byte_we_i[b]) stage_q[b*8 +: 8] <= wdata_i;
    end
  end

  assign early_o = act_q && end_i && !arm && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= {stage_q[CNT_W-1:8], wdata_i};
      act_q <= ({stage_q[CNT_W-1:8], wdata_i} != '0);
    end else if (abort_i || early_o) begin
      act_q <= 1'b0;
    end else if (act_q && strobe_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;
endmodule

// File: rtl/ata_ctl_reg.sv
module ata_ctl_reg
  import ata_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       arm_i,
  input  logic       early_i,
  input  logic       pio_start_i,
  input  logic       pio_done_i,
  output ctl_t       ctl_o,
  output logic [7:0] rd_o
);
  ctl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (wr_i) begin
        q.oe     <= wdata_i[CTL_OE];
        q.tog    <= wdata_i[CTL_TOG];
        q.auto_x <= wdata_i[CTL_AUTO];
        q.udma   <= wdata_i[CTL_UDMA];
      end
      // hardware set beats clears
      if (pio_done_i)                                q.pio <= 1'b1;
      else if (pio_start_i || (wr_i && wdata_i[CTL_PIO])) q.pio <= 1'b0;

      if (arm_i)                             q.abort <= 1'b0;
      else if (wr_i && wdata_i[CTL_ABORT])   q.abort <= 1'b1;

      if (arm_i)                                        q.err <= 1'b0;
      else if ((wr_i && wdata_i[CTL_ABORT]) || early_i) q.err <= 1'b1;
    end
  end

  assign ctl_o = q;
  always_comb begin
    rd_o           = q;
    rd_o[CTL_RSVD] = 1'b1;
  end
endmodule

// File: rtl/ata_rd_mux.sv
module ata_rd_mux #(
  parameter int         CNT_W    = 32,
  parameter logic [7:0] CNT_BASE = 8'hE1,
  parameter logic [7:0] CTL_ADDR = 8'hDD,
  localparam int        NB       = CNT_W / 8
) (
  input  logic [7:0]       addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       ctl_i,
  output logic [7:0]       rdata_o
);
  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == CTL_ADDR) rdata_o = ctl_i;
    for (int k = 0; k < NB; k++) begin
      if (addr_i == CNT_BASE + 8'(k)) rdata_o = cnt_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/ata_xfer_regs.sv
module ata_xfer_regs
  import ata_regs_pkg::*;
#(
  parameter int         CNT_W    = 32,
  parameter logic [7:0] CNT_BASE = 8'hE1,
  parameter logic [7:0] CTL_ADDR = 8'hDD
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       xfer_byte_i,
  input  logic       xfer_end_i,
  input  logic       pio_start_i,
  input  logic       pio_done_i,
  output logic       pin_oe_o,
  output logic       abort_o,
  output logic       err_o,
  output logic       xfer_active_o,
  output logic       buf_hold_o,
  output logic       buf_tog_en_o,
  output logic       auto_xfer_o,
  output logic       udma_en_o,
  output logic       pio_irq_o
);
  localparam int NB = CNT_W / 8;

  logic [NB-1:0]    byte_we;
  logic             arm_w;
  logic             ctl_we;
  logic             abort_req;
  logic             early;
  logic [CNT_W-1:0] cnt_q;
  ctl_t             ctl;
  logic [7:0]       ctl_rd;

  for (genvar k = 0; k < NB; k++) begin : g_dec
    assign byte_we[k] = reg_we_i && (reg_addr_i == CNT_BASE + 8'(k));
  end
  assign arm_w     = byte_we[0];
  assign ctl_we    = reg_we_i && (reg_addr_i == CTL_ADDR);
  assign abort_req = ctl_we && reg_wdata_i[CTL_ABORT];

  ata_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_we_i (byte_we),
    .wdata_i   (reg_wdata_i),
    .abort_i   (abort_req),
    .end_i     (xfer_end_i),
    .strobe_i  (xfer_byte_i),
    .cnt_o     (cnt_q),
    .active_o  (xfer_active_o),
    .early_o   (early)
  );

  ata_ctl_reg u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctl_we),
    .wdata_i     (reg_wdata_i),
    .arm_i       (arm_w),
    .early_i     (early),
    .pio_start_i (pio_start_i),
    .pio_done_i  (pio_done_i),
    .ctl_o       (ctl),
    .rd_o        (ctl_rd)
  );

  ata_rd_mux #(.CNT_W(CNT_W), .CNT_BASE(CNT_BASE), .CTL_ADDR(CTL_ADDR)) u_rd (
    .addr_i  (reg_addr_i),
    .cnt_i   (cnt_q),
    .ctl_i   (ctl_rd),
    .rdata_o (reg_rdata_o)
  );

  assign pin_oe_o     = ctl.oe;
  assign abort_o      = ctl.abort;
  assign err_o        = ctl.err;
  assign buf_hold_o   = ctl.err;
  assign buf_tog_en_o = ctl.tog | ctl.auto_x;
  assign auto_xfer_o  = ctl.auto_x;
  assign udma_en_o    = ctl.udma;
  assign pio_irq_o    = ctl.pio;
endmodule

// File: rtl/ata_xfer_regs_chk.sv
module ata_xfer_regs_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pio_done_i,
  input logic             pio_irq_o,
  input logic             abort_o,
  input logic             err_o,
  input logic             xfer_active_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             arm_i
);
  assert_pio_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pio_done_i |=> pio_irq_o);

  assert_abort_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> err_o);

  assert_err_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !xfer_active_o);

  assert_active_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_active_o |-> (cnt_i != '0));

  assert_idle_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_active_o && !arm_i) |=> $stable(cnt_i));

  assert_arm_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!err_o && !abort_o));
endmodule

bind ata_xfer_regs ata_xfer_regs_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pio_done_i    (pio_done_i),
  .pio_irq_o     (pio_irq_o),
  .abort_o       (abort_o),
  .err_o         (err_o),
  .xfer_active_o (xfer_active_o),
  .cnt_i         (cnt_q),
  .arm_i         (arm_w)
);

// File: tb/ata_xfer_regs_tb_top.sv
`timescale 1ns/1ps
module ata_xfer_regs_tb_top;
  localparam logic [7:0] CB  = 8'hE1;
  localparam logic [7:0] CTL = 8'hDD;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic xfer_byte = 1'b0, xfer_end = 1'b0, pio_start = 1'b0, pio_done = 1'b0;
  logic [7:0] rdata;
  logic pin_oe, abort_f, err_f, active, hold, tog, auto_x, udma, irq;

  always #2 clk = ~clk;

  ata_xfer_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .xfer_byte_i(xfer_byte),
    .xfer_end_i(xfer_end), .pio_start_i(pio_start), .pio_done_i(pio_done),
    .pin_oe_o(pin_oe), .abort_o(abort_f), .err_o(err_f), .xfer_active_o(active),
    .buf_hold_o(hold), .buf_tog_en_o(tog), .auto_xfer_o(auto_x),
    .udma_en_o(udma), .pio_irq_o(irq)
  );

  int checks = 0, fails = 0;
  string scen = "R1";

  int unsigned m_cnt = 0, m_stage = 0;
  bit m_act, m_abort, m_err, m_pio, m_oe, m_tog, m_auto, m_udma;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == CTL) return {m_oe, m_pio, m_abort, m_err, m_tog, m_auto, 1'b1, m_udma};
    for (int k = 0; k < 4; k++) if (a == CB + 8'(k)) return 8'(m_cnt >> (8*k));
    return 8'h00;
  endfunction

  task automatic model_step();
    bit arm, ctlw, abt;
    arm  = reg_we && reg_addr == CB;
    ctlw = reg_we && reg_addr == CTL;
    abt  = ctlw && reg_wdata[5];
    if (arm) begin
      m_cnt = (m_stage & 32'hFFFF_FF00) | reg_wdata;
      m_act = m_cnt != 0; m_abort = 0; m_err = 0;
    end else if (abt) begin
      m_abort = 1; m_err = 1; m_act = 0;
    end else if (m_act && xfer_end) begin
      m_err = 1; m_act = 0;
    end else if (m_act && xfer_byte) begin
      m_cnt--;
      if (m_cnt == 0) m_act = 0;
    end
    for (int k = 1; k < 4; k++)
      if (reg_we && reg_addr == CB + 8'(k))
        m_stage = (m_stage & ~(32'hFF << (8*k))) | (32'(reg_wdata) << (8*k));
    if (ctlw) begin
      m_oe = reg_wdata[7]; m_tog = reg_wdata[3]; m_auto = reg_wdata[2]; m_udma = reg_wdata[0];
    end
    if (pio_done) m_pio = 1;
    else if (pio_start || (ctlw && reg_wdata[6])) m_pio = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  task automatic compare();
    chk(rdata, m_read(reg_addr), (reg_addr == CTL) ? "R9" : "R3");
    chk(active, m_act, "R4");
    chk(abort_f, m_abort, "R5");
    chk(err_f, m_err, "R6");
    chk(hold, m_err, "R11");
    chk(tog, m_tog | m_auto, "R10");
    chk(pin_oe, m_oe, "R9");
    chk(auto_x, m_auto, "R9");
    chk(udma, m_udma, "R9");
    chk(irq, m_pio, "R8");
  endtask

  // one clock: drive after negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit w, input logic [7:0] a, input logic [7:0] d,
                     input bit s = 0, input bit e = 0, input bit ps = 0, input bit pd = 0);
    reg_we = w; reg_addr = a; reg_wdata = d;
    xfer_byte = s; xfer_end = e; pio_start = ps; pio_done = pd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rd_all();
    for (int k = 0; k < 4; k++) cyc(0, CB + 8'(k), 0);
    cyc(0, CTL, 0);
  endtask

  task automatic arm32(input logic [31:0] v);
    cyc(1, CB + 8'd3, v[31:24]);
    cyc(1, CB + 8'd2, v[23:16]);
    cyc(1, CB + 8'd1, v[15:8]);
    cyc(1, CB, v[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog [%s] actual=hung expected=done", scen);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    scen = "R1"; compare(); rd_all();

    scen = "R2";
    cyc(1, CB + 8'd3, 8'h00); cyc(1, CB + 8'd2, 8'h00); cyc(1, CB + 8'd1, 8'h01);
    cyc(0, CB + 8'd1, 0);
    cyc(1, CB, 8'h03); rd_all();

    scen = "R4";
    for (int i = 0; i < 4; i++) cyc(0, CB, 0, 1);
    arm32(32'h0000_0003);
    for (int i = 0; i < 5; i++) cyc(0, CB, 0, 1);
    cyc(0, CB, 0, 1); rd_all();

    scen = "R3";
    arm32(32'hA1B2_C3D4); rd_all();
    cyc(0, 8'h55, 0);

    scen = "R5";
    cyc(0, CB, 0, 1); cyc(0, CB, 0, 1);
    cyc(1, CTL, 8'h20);
    cyc(0, CB, 0, 1); cyc(0, CB, 0, 1);
    cyc(1, CTL, 8'h00); rd_all();

    scen = "R7";
    arm32(32'h0000_0010);
    cyc(1, CB, 8'h08, 0, 1);
    cyc(0, CB, 0, 1);

    scen = "R6";
    cyc(0, CB, 0, 0, 1);
    cyc(0, CB, 0, 1); cyc(0, CB, 0, 0, 1);
    arm32(32'h0000_0000);
    cyc(0, CB, 0, 1, 1); rd_all();

    scen = "R12";
    arm32(32'h0001_0000);
    cyc(0, CB + 8'd2, 0, 1);
    cyc(1, CTL, 8'h20, 1);
    cyc(0, CB, 0);
    arm32(32'h0000_0005);
    cyc(0, CB, 0, 1, 1);
    cyc(0, CB, 0);

    scen = "R8";
    cyc(0, CTL, 0, 0, 0, 0, 1);
    cyc(0, CTL, 0, 0, 0, 1, 0);
    cyc(0, CTL, 0, 0, 0, 0, 1);
    cyc(1, CTL, 8'h40);
    cyc(0, CTL, 0, 0, 0, 0, 1);
    cyc(1, CTL, 8'h40, 0, 0, 0, 1);
    cyc(0, CTL, 0, 0, 0, 1, 1);
    cyc(0, CTL, 0, 0, 0, 1, 0);

    scen = "R9";
    cyc(1, CTL, 8'h8D); cyc(1, CTL, 8'h01); cyc(1, CTL, 8'h80);

    scen = "R10";
    cyc(1, CTL, 8'h04); cyc(1, CTL, 8'h08); cyc(1, CTL, 8'h0C); cyc(1, CTL, 8'h00);

    scen = "R11";
    arm32(32'h0000_0002);
    cyc(0, CTL, 0, 0, 1);
    cyc(1, CB, 8'h01);
    cyc(0, CTL, 0, 1); rd_all();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule